// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block drives a multi-channel successive-approximation analog-to-digital converter from a small word-addressed register file. Software programs a settle count, then writes the control word with a channel number, the power bit and optionally the interrupt enable. The write powers the converter and starts a conversion. The sequencer waits the programmed number of converter ticks, then resolves the code one bit per tick, starting with the most significant bit. Each trial code goes to the DAC port, and the comparator input decides whether the bit stays.

When the last bit is resolved, the result is stored right-justified in the result word, the busy flag clears and the completion flag in the control word is set. The interrupt line is high while both the completion flag and the interrupt enable are set. Writing zero to the control word clears the completion flag and removes converter power. The converter pace comes from a single-cycle tick enable, so a slow converter clock is modelled without a second clock domain.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq` and `adc_pwr` are low.
- R2: Word map by address bits [ADDR_W-1:2]: 0 result, 1 status, 2 control, 3 settle count; any other word reads zero. Control bits are channel [2:0], power [3], interrupt enable [5] and completion flag [6]. The settle count is 6 bits wide. All bits not listed read zero, and `reg_rdata` is valid one cycle after the address is presented.
- R3: A control write with bit 3 set while idle starts a conversion, and status bit 0 reads 1 from then until that conversion ends.
- R4: A conversion ends exactly N+RES ticks after the starting write, where N is the settle count. A count of zero means no wait.
- R5: Trials run MSB first; the first trial code is the MSB alone. A bit stays when `cmp_in` is 1, so with an ideal comparator the result equals the input level.
- R6: The result appears in bits [RES-1:0] of word 0 with the upper bits zero. It holds its value until the next conversion completes.
- R7: Completion sets control bit 6, and `irq` equals bit 6 AND bit 5.
- R8: A control write with bit 6 at 0 clears the completion flag; writing 1 there leaves it unchanged. Writing zero to control drops `irq` and `adc_pwr`.
- R9: While busy, a control write with bit 3 set is ignored entirely.
- R10: While busy, a control write with bit 3 clear aborts the conversion: busy clears, no completion is flagged and the result word is unchanged.
- R11: `chan_sel` and `adc_pwr` follow the stored channel and power bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| conv_tick | input | 1 | Single-cycle converter clock enable |
| cmp_in | input | 1 | Comparator: 1 when input level >= DAC level |
| dac_code | output | RES | Current trial code |
| chan_sel | output | 3 | Selected input channel |
| adc_pwr | output | 1 | Converter power enable |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with RES=10 and ADDR_W=5. With ADDR_W=5, an unmapped word exists, so the zero read-back for unused addresses can be observed. Ten-bit codes make both rails, the mid-scale neighbours 511 and 512, and random levels quick to resolve through an ideal comparator model. Settle counts of 0, 1 and the 63 maximum, together with random ticks, check the exact tick count of each conversion. Busy-time writes of both kinds are checked for being ignored or aborting.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_TRIAL} seq_state_t;

  localparam int unsigned WORD_RESULT  = 0;
  localparam int unsigned WORD_STATUS  = 1;
  localparam int unsigned WORD_CONTROL = 2;
  localparam int unsigned WORD_SETTLE  = 3;

  localparam int unsigned CHAN_W = 3;
  localparam int unsigned DLY_W  = 6;
  localparam int unsigned CB_PWR = 3;
  localparam int unsigned CB_IEN = 5;
  localparam int unsigned CB_IST = 6;
endpackage

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int unsigned RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic           cmp_in,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result,
  output logic           last
);
  logic [RES-1:0] mask_q;
  logic [RES-1:0] trial_q;
  localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

  // bit under trial is kept when the input is at or above the trial level
  assign result = cmp_in ? trial_q : (trial_q & ~mask_q);
  assign trial  = trial_q;
  assign last   = mask_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (load) begin
      trial_q <= TOP_BIT;
      mask_q  <= TOP_BIT;
    end else if (step) begin
      trial_q <= result | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end

  // R5
  mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask_q));
  // R5
  step_has_bit_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> (mask_q != '0));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned SW = DLY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          tick,
  input  logic          last,
  input  logic [SW-1:0] settle,
  output logic          busy,
  output logic          load,
  output logic          step,
  output logic          done
);
  seq_state_t    state_q;
  logic [SW-1:0] cnt_q;

  assign busy = (state_q != ST_IDLE);
  assign load = ((state_q == ST_IDLE) && start && (settle == '0)) ||
                ((state_q == ST_WAIT) && tick && !abort && (cnt_q == SW'(1)));
  assign step = (state_q == ST_TRIAL) && tick && !abort;
  assign done = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          cnt_q   <= settle;
          state_q <= (settle == '0) ? ST_TRIAL : ST_WAIT;
        end
        ST_WAIT: if (abort) begin
          state_q <= ST_IDLE;
        end else if (tick) begin
          if (cnt_q == SW'(1)) state_q <= ST_TRIAL;
          cnt_q <= cnt_q - SW'(1);
        end
        ST_TRIAL: if (abort || done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  wait_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> (cnt_q != '0));
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> !busy);
endmodule

// File: rtl/sar_regs.sv
module sar_regs
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned RES    = 10,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              conv_done,
  input  logic [RES-1:0]    conv_result,
  output logic [DATA_W-1:0] rdata,
  output logic [CHAN_W-1:0] chan,
  output logic              pwr,
  output logic              ien,
  output logic              ist,
  output logic [DLY_W-1:0]  settle,
  output logic              start,
  output logic              abort
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              is_ctrl, is_settle, ctrl_wr, accept;
  logic [RES-1:0]    result_q;
  logic              unused_bits;

  assign word      = addr[ADDR_W-1:2];
  assign is_ctrl   = (word == WORD_W'(WORD_CONTROL));
  assign is_settle = (word == WORD_W'(WORD_SETTLE));
  assign ctrl_wr   = wr_en && is_ctrl;
  assign accept    = ctrl_wr && (!busy || !wdata[CB_PWR]);
  assign start     = accept && wdata[CB_PWR];
  assign abort     = ctrl_wr && busy && !wdata[CB_PWR];
  assign unused_bits = ^{wdata[DATA_W-1:CB_IST+1], wdata[4], addr[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      chan     <= '0;
      pwr      <= 1'b0;
      ien      <= 1'b0;
      ist      <= 1'b0;
      settle   <= '0;
      result_q <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        chan <= wdata[CHAN_W-1:0];
        pwr  <= wdata[CB_PWR];
        ien  <= wdata[CB_IEN];
      end
      if (conv_done)                    ist <= 1'b1;
      else if (accept && !wdata[CB_IST]) ist <= 1'b0;
      if (wr_en && is_settle) settle <= wdata[DLY_W-1:0];
      if (conv_done) result_q <= conv_result;

      rdata <= '0;
      case (word)
        WORD_W'(WORD_RESULT):  rdata[RES-1:0] <= result_q;
        WORD_W'(WORD_STATUS):  rdata[0] <= busy;
        WORD_W'(WORD_CONTROL): begin
          rdata[CHAN_W-1:0] <= chan;
          rdata[CB_PWR]     <= pwr;
          rdata[CB_IEN]     <= ien;
          rdata[CB_IST]     <= ist;
        end
        WORD_W'(WORD_SETTLE):  rdata[DLY_W-1:0] <= settle;
        default: ;
      endcase
    end
  end

  // R7
  flag_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ist) |-> $past(busy));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr && wdata[CB_PWR]) |=> ($stable(chan) && $stable(ien)));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(result_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int unsigned RES    = 10,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              conv_tick,
  input  logic              cmp_in,
  output logic [RES-1:0]    dac_code,
  output logic [2:0]        chan_sel,
  output logic              adc_pwr,
  output logic              irq
);
  logic              busy, load, step, done, last, start, abort;
  logic              ien, ist;
  logic [DLY_W-1:0]  settle;
  logic [RES-1:0]    res_bits;

  sar_regs #(.RES(RES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .conv_done(done), .conv_result(res_bits), .rdata(reg_rdata),
    .chan(chan_sel), .pwr(adc_pwr), .ien(ien), .ist(ist), .settle(settle),
    .start(start), .abort(abort)
  );

  sar_seq #(.SW(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .tick(conv_tick),
    .last(last), .settle(settle), .busy(busy), .load(load), .step(step),
    .done(done)
  );

  sar_approx #(.RES(RES)) u_approx (
    .clk(clk), .rst(rst), .load(load), .step(step), .cmp_in(cmp_in),
    .trial(dac_code), .result(res_bits), .last(last)
  );

  assign irq = ist & ien;

  // R10
  busy_powered_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> adc_pwr);
endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  localparam int RES = 10;
  localparam int AW  = 5;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic conv_tick = 1'b0;
  logic cmp_in;
  logic [RES-1:0] dac_code;
  logic [2:0] chan_sel;
  logic adc_pwr, irq;
  logic [RES-1:0] vin [8];
  int total = 0;
  int bad = 0;
  int tickcnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sar_conv_ctrl #(.RES(RES), .ADDR_W(AW), .DATA_W(DW)) i_sar_conv_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_tick(conv_tick),
    .cmp_in(cmp_in), .dac_code(dac_code), .chan_sel(chan_sel),
    .adc_pwr(adc_pwr), .irq(irq)
  );

  assign cmp_in = (vin[chan_sel] >= dac_code);

  always @(posedge clk) if (conv_tick) tickcnt <= tickcnt + 1;

  initial begin
    void'($urandom(32'd2024));
    forever @(negedge clk) conv_tick <= (($urandom % 3) == 0);
  end

  function automatic int exp_ticks(int n);
    return n + RES;
  endfunction

  function automatic logic [DW-1:0] exp_ctrl(int ch, bit p, bit ie, bit fl);
    return DW'(ch & 7) | (DW'(p) << 3) | (DW'(ie) << 5) | (DW'(fl) << 6);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    reg_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic convert(int ch, int n, logic [RES-1:0] v);
    logic [DW-1:0] d;
    int t0;
    vin[ch] = v;
    wr(12, DW'(n));
    wr(8, exp_ctrl(ch, 1, 1, 0));
    t0 = tickcnt;
    if (n == 0) check(dac_code == {1'b1, {(RES-1){1'b0}}}, "R5 first trial",
                      dac_code, {1'b1, {(RES-1){1'b0}}});
    check(chan_sel == 3'(ch), "R11 chan_sel", chan_sel, ch);
    wait_irq();
    check(tickcnt - t0 == exp_ticks(n), "R4 tick count", tickcnt - t0, exp_ticks(n));
    rd(0, d);
    check(d == DW'(v), "R5 R6 result", d, v);
    rd(4, d);
    check(d == 0, "R3 busy low after end", d, 0);
    rd(8, d);
    check(d == exp_ctrl(ch, 1, 1, 1), "R7 completion flag", d, exp_ctrl(ch, 1, 1, 1));
    wr(8, 0);
    check(!irq && !adc_pwr, "R8 clear and power down", {irq, adc_pwr}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(a, d);
      check(d == 0, "R1 reset read", d, 0);
    end
    check(!irq && !adc_pwr, "R1 outputs", {irq, adc_pwr}, 0);

    // R2 layout
    wr(12, 32'hFFFF_FFFF);
    rd(12, d);
    check(d == 32'h3F, "R2 settle width", d, 32'h3F);
    wr(8, 32'hFFFF_FFB7);
    rd(8, d);
    check(d == 32'h27, "R2 control bits", d, 32'h27);
    check(chan_sel == 3'd7 && !adc_pwr, "R11 outputs", {chan_sel, adc_pwr}, 8'he);
    rd(16, d);
    check(d == 0, "R2 unmapped word", d, 0);
    wr(8, 0);

    // directed conversions: rails, mid-scale, settle extremes
    convert(0, 0, 10'd0);
    convert(1, 1, 10'd1023);
    convert(2, 63, 10'd512);
    convert(3, 0, 10'd511);
    convert(4, 2, 10'd341);

    // R3 busy while waiting
    vin[6] = 10'd77;
    wr(12, 63);
    wr(8, exp_ctrl(6, 1, 1, 0));
    rd(4, d);
    check(d == 1, "R3 busy reads 1", d, 1);
    // R9 start-write while busy ignored
    wr(8, exp_ctrl(5, 1, 0, 0));
    rd(8, d);
    check(d == exp_ctrl(6, 1, 1, 0), "R9 busy write ignored", d, exp_ctrl(6, 1, 1, 0));
    check(chan_sel == 3'd6, "R9 channel kept", chan_sel, 6);
    wait_irq();
    rd(0, d);
    check(d == 77, "R9 result of first start", d, 77);
    wr(8, 0);

    // R10 abort
    vin[1] = 10'd900;
    wr(12, 20);
    wr(8, exp_ctrl(1, 1, 1, 0));
    repeat (10) @(negedge clk);
    wr(8, exp_ctrl(0, 0, 1, 0));
    rd(4, d);
    check(d == 0, "R10 abort clears busy", d, 0);
    repeat (300) @(negedge clk);
    check(!irq, "R10 no completion", irq, 0);
    rd(0, d);
    check(d == 77, "R10 result unchanged", d, 77);
    rd(8, d);
    check(d == exp_ctrl(0, 0, 1, 0), "R10 control after abort", d, exp_ctrl(0, 0, 1, 0));

    // R7 and R8 flag handling with interrupt disabled
    vin[3] = 10'd600;
    wr(12, 3);
    wr(8, exp_ctrl(3, 1, 0, 0));
    d = 1;
    while (d[0]) begin
      rd(4, d);
      check(!irq, "R7 irq masked", irq, 0);
    end
    rd(8, d);
    check(d == exp_ctrl(3, 1, 0, 1), "R7 flag set when masked", d, exp_ctrl(3, 1, 0, 1));
    wr(8, exp_ctrl(3, 0, 1, 1));
    check(irq, "R8 writing 1 keeps flag, R7 irq follows enable", irq, 1);
    wr(8, exp_ctrl(3, 0, 1, 0));
    check(!irq, "R8 writing 0 clears flag", irq, 0);
    rd(0, d);
    check(d == 600, "R6 masked conversion result", d, 600);
    wr(8, 0);

    // random conversions
    for (int k = 0; k < 20; k++) begin
      convert(int'($urandom % 8), int'($urandom % 16), RES'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule